// File: doc/BRIEF.md
# Cache Region Maintenance Engine

This block walks a programmed address range of a system-level cache and asks the cache array to write back, drop, or write back and then drop each line in that range. Software programs it through a small register port. It sets the operation in a control register, writes the last address of the range, and then writes the first address. That last write starts the walk. Software then polls a busy flag until the walk has finished.

Toward the cache array the block presents one line request at a time. The request carries a line-aligned address and a two-bit operation. The block holds the request until the array acknowledges it, then moves to the next line. A configuration register reports the line size and the capacity that were chosen by parameter. A disable bit in the control register is driven out to the cache as a plain level.

Top module: `region_maint_engine`

## Requirements
- R1: After reset, the control, region-start and region-end registers read 0, `line_req` is low and `cache_off` is low.
- R2: The configuration register (0x901) reads bit 4 as the line-size field (0 means 128-byte lines, 1 means 64-byte lines) and bits 3..0 as the capacity code (capacity is 128 KB shifted left by the code). All other bits read 0.
- R3: A write to the region-end register (0x916) only stores the value. No line request follows it, and the busy flag stays 0.
- R4: A write to the region-start register (0x914) while the engine is idle starts a walk. The busy flag (control bit 8, read-only) reads 1 from the cycle after that write. It keeps reading 1 until the acknowledge of the last line has been taken, then reads 0.
- R5: The walk issues one request per line, in ascending order. It runs from the line that holds the start address to the line that holds the end address, both included. `line_addr` carries the line address with the offset bits at zero. The next request is issued only after `line_ack`.
- R6: If the end line is below the start line, only the start line is processed.
- R7: `line_op` bit 0 means write back and bit 1 means invalidate. Control bits 11..9 hold the region code. When bit 9 is 0 the operation is write back only (01). When bit 9 is 1 and mode bit 6 is 0 the operation is invalidate only (10). When bit 9 is 1 and mode bit 6 is 1 the operation is write back and then invalidate (11). Bits 11..10 do not change the operation.
- R8: The offset bits of values written to the start and end registers are ignored. Both registers read back line-aligned.
- R9: While busy, writes to the start, end and control registers are ignored. They start nothing, and reads show the earlier values.
- R10: While `line_req` is high and `line_ack` is low, the request, its address and its operation stay unchanged on the next cycle.
- R11: `cache_off` follows control bit 0. The control register reads back bits 0, 6 and 11..9 as written, and all other writable bits read 0.
- R12: Writes to the full-flush (0x904) and full-invalidate (0x905) registers change no readable register and start no walk. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| line_req | output | 1 | Line maintenance request |
| line_addr | output | ADDR_W | Line-aligned address of the requested line |
| line_op | output | 2 | Bit 0 write back, bit 1 invalidate |
| line_ack | input | 1 | Cache array has completed the requested line |
| cache_off | output | 1 | Cache disable level from control bit 0 |

## Verification
The assertions check the handshake on every cycle. A waiting request must hold its address and operation. Requested addresses must be line-aligned with a nonzero operation. After an acknowledge the address must step by exactly one line or the request must drop. An idle engine may start only on a write of the start register. Only the bench scenarios can show the rest: the exact set and count of lines for each range, the mapping from region code and mode bit to operation, the reversed-range case, the writes ignored while busy, and the register read-back values.

// File: rtl/rme_pkg.sv
package rme_pkg;
   localparam logic [11:0] RA_CFG   = 12'h901;
   localparam logic [11:0] RA_CTRL  = 12'h903;
   localparam logic [11:0] RA_FFLSH = 12'h904;
   localparam logic [11:0] RA_FINV  = 12'h905;
   localparam logic [11:0] RA_START = 12'h914;
   localparam logic [11:0] RA_END   = 12'h916;

   localparam int CB_DIS  = 0;
   localparam int CB_MODE = 6;
   localparam int CB_BUSY = 8;
   localparam int CB_CODE = 9;

   typedef struct packed {
      logic inv;
      logic wb;
   } line_op_t;
endpackage

// File: rtl/rme_opdec.sv
module rme_opdec
   import rme_pkg::*;
(
   input  logic [2:0] code,
   input  logic       mode,
   output line_op_t   op
);
   always_comb begin
      if (!code[0]) begin
         op.wb  = 1'b1;
         op.inv = 1'b0;
      end else begin
         op.wb  = mode;
         op.inv = 1'b1;
      end
   end
endmodule

// File: rtl/rme_regs.sv
module rme_regs
   import rme_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int CAP_CODE   = 2,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LW        = ADDR_W - OFF_W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [11:0]   addr,
   input  logic [31:0]   wdata,
   input  logic          busy,
   output logic [31:0]   rdata,
   output logic          trig,
   output logic [LW-1:0] trig_line,
   output logic [LW-1:0] end_line,
   output logic [2:0]    code,
   output logic          mode,
   output logic          dis
);
   logic [LW-1:0] start_q, end_q;
   logic          ls_field;
   logic [31:0]   cfg_word;

   if (LINE_BYTES == 128) begin : g_ls128
      assign ls_field = 1'b0;
   end else begin : g_ls64
      assign ls_field = 1'b1;
   end

   assign cfg_word  = {27'b0, ls_field, 4'(CAP_CODE)};
   assign trig_line = wdata[ADDR_W-1:OFF_W];
   assign trig      = we && (addr == RA_START) && !busy;
   assign end_line  = end_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         end_q   <= '0;
         code    <= '0;
         mode    <= 1'b0;
         dis     <= 1'b0;
      end else if (we && !busy) begin
         case (addr)
            RA_START: start_q <= trig_line;
            RA_END:   end_q   <= wdata[ADDR_W-1:OFF_W];
            RA_CTRL: begin
               dis  <= wdata[CB_DIS];
               mode <= wdata[CB_MODE];
               code <= wdata[CB_CODE+2:CB_CODE];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         RA_CFG:   rdata = cfg_word;
         RA_CTRL:  rdata = {20'b0, code, busy, 1'b0, mode, 5'b0, dis};
         RA_START: rdata = 32'({start_q, {OFF_W{1'b0}}});
         RA_END:   rdata = 32'({end_q, {OFF_W{1'b0}}});
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/rme_walker.sv
module rme_walker
   import rme_pkg::*;
#(
   parameter int LW = 26
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic [LW-1:0] trig_line,
   input  logic [LW-1:0] end_line,
   input  line_op_t      op_in,
   input  logic          ack,
   output logic          busy,
   output logic [LW-1:0] cur_line,
   output line_op_t      op_q
);
   logic [LW-1:0] last_line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cur_line  <= '0;
         last_line <= '0;
         op_q      <= '0;
      end else if (!busy) begin
         if (trig) begin
            busy      <= 1'b1;
            cur_line  <= trig_line;
            last_line <= end_line;
            op_q      <= op_in;
         end
      end else if (ack) begin
         if (cur_line >= last_line) busy <= 1'b0;
         else cur_line <= cur_line + 1'b1;
      end
   end
endmodule

// File: rtl/region_maint_engine.sv
module region_maint_engine
   import rme_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int CAP_CODE   = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              line_req,
   output logic [ADDR_W-1:0] line_addr,
   output logic [1:0]        line_op,
   input  logic              line_ack,
   output logic              cache_off
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int LW    = ADDR_W - OFF_W;

   if (LINE_BYTES != 64 && LINE_BYTES != 128) begin : g_bad_line
      $error("LINE_BYTES must be 64 or 128");
   end
   if (ADDR_W > 32 || ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (CAP_CODE < 0 || CAP_CODE > 15) begin : g_bad_cap
      $error("CAP_CODE must fit in four bits");
   end

   logic          busy, trig, mode;
   logic [2:0]    code;
   logic [LW-1:0] trig_line, end_line, cur_line;
   line_op_t      op_dec, op_q;

   rme_regs #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CAP_CODE(CAP_CODE)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .busy(busy), .rdata(reg_rdata), .trig(trig), .trig_line(trig_line),
      .end_line(end_line), .code(code), .mode(mode), .dis(cache_off)
   );

   rme_opdec u_dec (.code(code), .mode(mode), .op(op_dec));

   rme_walker #(.LW(LW)) u_walk (
      .clk(clk), .rst_n(rst_n), .trig(trig), .trig_line(trig_line),
      .end_line(end_line), .op_in(op_dec), .ack(line_ack),
      .busy(busy), .cur_line(cur_line), .op_q(op_q)
   );

   assign line_req  = busy;
   assign line_addr = {cur_line, {OFF_W{1'b0}}};
   assign line_op   = busy ? op_q : 2'b00;
endmodule

// File: rtl/rme_checker.sv
module rme_checker
   import rme_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [11:0]       reg_addr,
   input logic              line_req,
   input logic [ADDR_W-1:0] line_addr,
   input logic [1:0]        line_op,
   input logic              line_ack
);
   localparam int OFF_W = $clog2(LINE_BYTES);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      line_req && !line_ack |=> line_req && $stable(line_addr) && $stable(line_op));

   p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_req |-> line_addr[OFF_W-1:0] == '0);

   p_op_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_req |-> line_op != 2'b00);

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_req && line_ack |=> !line_req ||
         line_addr == ADDR_W'($past(line_addr) + ADDR_W'(LINE_BYTES)));

   p_start_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !line_req && !(reg_we && reg_addr == RA_START) |=> !line_req);
endmodule

bind region_maint_engine rme_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .line_req(line_req), .line_addr(line_addr), .line_op(line_op), .line_ack(line_ack)
);

// File: tb/region_maint_engine_bench.sv
module region_maint_engine_bench;
   localparam int AW  = 16;
   localparam int LB  = 64;
   localparam int CAP = 3;
   localparam logic [31:0] AMASK = 32'h0000_FFC0;

   logic          clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, line_ack = 1'b0;
   logic [11:0]   reg_addr = '0;
   logic [31:0]   reg_wdata = '0, reg_rdata;
   logic          line_req, cache_off;
   logic [AW-1:0] line_addr;
   logic [1:0]    line_op;
   int            checks = 0, fails = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   region_maint_engine #(.ADDR_W(AW), .LINE_BYTES(LB), .CAP_CODE(CAP)) u_region_maint_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_req(line_req),
      .line_addr(line_addr), .line_op(line_op), .line_ack(line_ack),
      .cache_off(cache_off)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic run_region(input logic [31:0] s, input logic [31:0] e,
                             input logic [2:0] code, input bit im, input bit poke);
      logic [31:0] v, ctrl_w;
      int sl, el, cnt, n;
      logic [1:0] eop;
      ctrl_w = (32'(code) << 9) | (32'(im) << 6);
      wr(12'h903, ctrl_w);
      wr(12'h916, e);
      rd(12'h903, v);
      chk(v[8] == 1'b0 && !line_req, "R3 end write starts nothing", {31'b0, line_req}, 0);
      sl  = int'(s >> 6);
      el  = int'(e >> 6);
      cnt = (el >= sl) ? el - sl + 1 : 1;
      eop = !code[0] ? 2'b01 : (im ? 2'b11 : 2'b10);
      wr(12'h914, s);
      rd(12'h903, v);
      chk(v[8] == 1'b1, "R4 busy after start", v, 32'h100);
      if (poke) begin
         wr(12'h916, 32'h3000);
         wr(12'h903, 32'h0000_0C41);
         wr(12'h914, 32'h2000);
         rd(12'h916, v);
         chk(v == (e & AMASK), "R9 end write ignored while busy", v, e & AMASK);
         rd(12'h903, v);
         chk(v == (ctrl_w | 32'h100), "R9 ctrl write ignored while busy", v, ctrl_w | 32'h100);
         chk(cache_off == 1'b0, "R9 disable unchanged while busy", {31'b0, cache_off}, 0);
      end
      n = 0;
      while (line_req && n < 64) begin
         repeat (n % 3) begin
            @(negedge clk);
         end
         chk(line_addr == AW'((sl + n) * LB), "R5 line address",
             32'(line_addr), 32'((sl + n) * LB));
         chk(line_op == eop, "R7 line operation", 32'(line_op), 32'(eop));
         line_ack = 1'b1;
         @(negedge clk);
         line_ack = 1'b0;
         n++;
         rd(12'h903, v);
         chk(v[8] == (n < cnt), "R4 busy while lines remain", 32'(v[8]), 32'(n < cnt));
      end
      chk(n == cnt, (el < sl) ? "R6 reversed range count" : "R5 line count",
          32'(n), 32'(cnt));
      rd(12'h914, v);
      chk(v == (s & AMASK), "R8 start aligned", v, s & AMASK);
      rd(12'h916, v);
      chk(v == (e & AMASK), "R8 end aligned", v, e & AMASK);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(12'h903, v); chk(v == 0, "R1 ctrl reset", v, 0);
      rd(12'h914, v); chk(v == 0, "R1 start reset", v, 0);
      rd(12'h916, v); chk(v == 0, "R1 end reset", v, 0);
      chk(!line_req && !cache_off, "R1 outputs idle", {30'b0, line_req, cache_off}, 0);
      rd(12'h901, v); chk(v == 32'h13, "R2 config word", v, 32'h13);

      wr(12'h903, 32'hFFFF_FFFF);
      rd(12'h903, v); chk(v == 32'h0E41, "R11 ctrl readback", v, 32'h0E41);
      chk(cache_off == 1'b1, "R11 disable high", {31'b0, cache_off}, 1);
      wr(12'h903, 32'h0);
      chk(cache_off == 1'b0, "R11 disable low", {31'b0, cache_off}, 0);

      wr(12'h916, 32'h0ABC);
      wr(12'h904, 32'hFFFF_FFFF);
      wr(12'h905, 32'hFFFF_FFFF);
      chk(!line_req, "R12 full ops start nothing", {31'b0, line_req}, 0);
      rd(12'h903, v); chk(v == 0, "R12 ctrl unchanged", v, 0);
      rd(12'h916, v); chk(v == 32'h0A80, "R12 end unchanged", v, 32'h0A80);
      rd(12'h914, v); chk(v == 0, "R12 start unchanged", v, 0);
      rd(12'h902, v); chk(v == 0, "R12 unmapped read", v, 0);

      for (int si = 0; si < 4; si++)
         for (int li = 0; li < 4; li++)
            for (int m = 0; m < 4; m++) begin
               logic [31:0] s;
               s = 32'(si * 32'h1C5 + 32'h40);
               case (m)
                  0: run_region(s, s + 32'(li * 32'h50), 3'b000, 1'b0, 1'b0);
                  1: run_region(s, s + 32'(li * 32'h50), 3'b001, 1'b0, 1'b0);
                  2: run_region(s, s + 32'(li * 32'h50), 3'b001, 1'b1, 1'b0);
                  default: run_region(s, s + 32'(li * 32'h50), 3'b110, 1'b1, 1'b0);
               endcase
            end

      run_region(32'h0400, 32'h0100, 3'b001, 1'b1, 1'b0);
      run_region(32'h1234, 32'h1234, 3'b000, 1'b0, 1'b0);
      run_region(32'hFFC0, 32'hFFFF, 3'b111, 1'b0, 1'b0);
      run_region(32'h0100, 32'h0200, 3'b001, 1'b0, 1'b1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule